// File: doc/BRIEF.md
# Power Island Up/Down Sequencer

This block steps one switchable power island between its off and on states. A request to power up or down starts a fixed, mirrored chain of control changes. The chain covers a two-stage power-switch enable, a clock-disable line, isolation, an active-low island reset, a field of SRAM power-down lines and a bus-protection request vector. Every handshake in the chain is a bounded wait on acknowledge inputs. Both power-status inputs must agree before the island counts as on or as off, and a split reading means the switch is still moving.

The block reports whether the island is on or off, whether a sequence is running, and whether a wait has run out of time. After a timeout it freezes every control line and ignores requests until software clears the error. The next request then runs the full ordering again from the lines as they were left. The SRAM acknowledge and bus-protection acknowledge checks use masks fixed at build time. A zero mask removes that handshake from the sequence.

Top module: `pwr_island_seq`

## Requirements
- R1: After reset, `ctl_word` holds bit 0 (reset, active low) = 0, bit 1 (isolation) = 1, bit 2 (first power enable) = 0, bit 3 (second power enable) = 0, bit 4 (clock disable) = 1, bits 7:5 = 0, and every SRAM power-down bit (from bit 8 up) = 1. `prot_req` equals `PROT_MASK`, `island_off` = 1, and `island_on`, `busy`, `seq_err` and `done` are 0.
- R2: A power-up request from off changes the outputs in this order: set bit 2, set bit 3, wait for power, clear bit 4, clear bit 1, set bit 0, clear all SRAM bits, wait for SRAM, clear `prot_req`, wait for protection. The result is `ctl_word` = 0x00D (SRAM bits 0) with `island_on` = 1.
- R3: The power-up wait ends only when both `pwr_ack_a` and `pwr_ack_b` are 1. While exactly one of them is 1, the wait continues.
- R4: The SRAM wait after power-up ends when every `sram_ack` bit selected by `SRAM_ACK_MASK` reads 0. Bits outside the mask have no effect.
- R5: Bus protection is released last on power-up, and the sequence completes only when the `prot_ack` bits in `PROT_MASK` read 0. On power-down it is raised first and waits for those bits to read 1.
- R6: A power-down request from on raises protection, then sets all SRAM bits and waits until every masked `sram_ack` bit reads 1. It then sets bit 1, clears bit 0, sets bit 4, clears bit 2 and clears bit 3, in that order.
- R7: The power-down wait ends only when both status inputs read 0, and the block then reports `island_off`.
- R8: With `SRAM_ACK_MASK` = 0 the SRAM waits are skipped, and with `PROT_MASK` = 0 the protection steps are skipped. Either way the acknowledge inputs are ignored, and up and down sequences each take 8 edges counting the one that samples the request.
- R9: If a wait lasts `WAIT_LIMIT` edges without its condition, `seq_err` rises on that edge. `ctl_word` and `prot_req` then stay unchanged while the error is set.
- R10: While `seq_err` is 1, requests are ignored. An `err_clr` returns the block to a state with `island_on` = `island_off` = 0, from which either request runs its full ordering.
- R11: An up request while on, or a down request while off, pulses `done` on the next edge and changes no control output.
- R12: At most one step (one control bit, the whole SRAM field, or the protection vector) changes per edge. Reset release, clock enable and isolation removal occur only while both power enables are set. `done` pulses on the edge that completes a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_on | input | 1 | Power-up request, sampled in idle states |
| req_off | input | 1 | Power-down request, sampled in idle states |
| err_clr | input | 1 | Clears a timeout error |
| pwr_ack_a | input | 1 | First power-switch status |
| pwr_ack_b | input | 1 | Second power-switch status |
| sram_ack | input | SRAM_ACK_W | SRAM power-down acknowledges |
| prot_ack | input | PROT_W | Bus-protection acknowledges |
| ctl_word | output | 8+SRAM_REQ_W | Island control lines (bit layout in R1) |
| prot_req | output | PROT_W | Bus-protection request |
| island_on | output | 1 | Island fully on |
| island_off | output | 1 | Island fully off |
| busy | output | 1 | Sequence in progress |
| seq_err | output | 1 | A handshake wait timed out |
| done | output | 1 | One-cycle pulse at sequence end or no-op request |

## Verification
On every cycle the assertions check several properties. At most one step changes per edge, and the resting on and off patterns are exact. Live signals appear only under both power enables. A split power reading never ends a power wait, and an error is both frozen and preceded by an expired timer. The exact ordering, the edge-accurate latency under different acknowledge delays, the skipping of handshakes with zero masks, and the behaviour around an error and its clearing can only be shown by the bench's scenarios.

// File: rtl/pwr_island_pkg.sv
// Shared definitions for the power island sequencer.
// Assumes the control word layout below is decoded by the island's switch fabric.
package pwr_island_pkg;

    localparam int BIT_RSTN   = 0;  // island reset, active low
    localparam int BIT_ISO    = 1;  // isolation clamp
    localparam int BIT_PON1   = 2;  // first power-switch stage
    localparam int BIT_PON2   = 3;  // second power-switch stage
    localparam int BIT_CLKDIS = 4;  // clock gate to island
    localparam int SRAM_LSB   = 8;  // first SRAM power-down line

    typedef enum logic [4:0] {
        S_OFF, S_ON, S_PART, S_ERR,
        U_PON1, U_PON2, U_WPWR, U_CLK, U_ISO, U_RST, U_SRAM, U_WSRAM, U_PROT, U_WPROT,
        D_PROT, D_WPROT, D_SRAM, D_WSRAM, D_ISO, D_RST, D_CLK, D_PON1, D_PON2, D_WPWR
    } seq_state_e;

endpackage

// File: rtl/pis_wait_timer.sv
// Bounded-wait counter. Counts edges spent in a wait state and flags the last
// allowed one. Assumes wait states are never entered back to back, so a cycle
// outside any wait reloads the count.
module pis_wait_timer #(
    parameter int LIMIT = 64,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic waiting,
    output logic expired
);
    logic [CW-1:0] cnt;

    // Reload outside waits, count inside, saturate at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !waiting) cnt <= '0;
        else if (!expired)      cnt <= cnt + 1'b1;
    end

    assign expired = waiting && (cnt == CW'(LIMIT - 1));

    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(LIMIT - 1));

endmodule

// File: rtl/pis_ack_decode.sv
// Reduces the raw acknowledge inputs to the conditions the sequencer waits on.
// A zero mask makes the matching condition constant true (handshake skipped).
module pis_ack_decode #(
    parameter int SRAM_ACK_W = 4,
    parameter logic [SRAM_ACK_W-1:0] SRAM_ACK_MASK = '1,
    parameter int PROT_W = 4,
    parameter logic [PROT_W-1:0] PROT_MASK = '1
) (
    input  logic                  pwr_ack_a,
    input  logic                  pwr_ack_b,
    input  logic [SRAM_ACK_W-1:0] sram_ack,
    input  logic [PROT_W-1:0]     prot_ack,
    output logic                  pwr_all_on,
    output logic                  pwr_all_off,
    output logic                  sram_clear,
    output logic                  sram_full,
    output logic                  prot_clear,
    output logic                  prot_full
);
    // Both status inputs must agree; a split reading is neither on nor off.
    assign pwr_all_on  = pwr_ack_a && pwr_ack_b;
    assign pwr_all_off = !pwr_ack_a && !pwr_ack_b;

    generate
        if (SRAM_ACK_MASK == '0) begin : g_no_sram_ack
            assign sram_clear = 1'b1;
            assign sram_full  = 1'b1;
        end else begin : g_sram_ack
            assign sram_clear = ((sram_ack & SRAM_ACK_MASK) == '0);
            assign sram_full  = ((sram_ack & SRAM_ACK_MASK) == SRAM_ACK_MASK);
        end
        if (PROT_MASK == '0) begin : g_no_prot
            assign prot_clear = 1'b1;
            assign prot_full  = 1'b1;
        end else begin : g_prot
            assign prot_clear = ((prot_ack & PROT_MASK) == '0);
            assign prot_full  = ((prot_ack & PROT_MASK) == PROT_MASK);
        end
    endgenerate

endmodule

// File: rtl/pwr_island_seq.sv
// Power island sequencer. Walks the island through mirrored up/down orderings,
// one control change per edge, with a bounded wait at each handshake. Assumes
// the acknowledge inputs are synchronous to clk. Handles a single island only.
module pwr_island_seq
    import pwr_island_pkg::*;
#(
    parameter int SRAM_REQ_W = 4,
    parameter int SRAM_ACK_W = 4,
    parameter logic [SRAM_ACK_W-1:0] SRAM_ACK_MASK = '1,
    parameter int PROT_W = 4,
    parameter logic [PROT_W-1:0] PROT_MASK = '1,
    parameter int WAIT_LIMIT = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_on,
    input  logic                       req_off,
    input  logic                       err_clr,
    input  logic                       pwr_ack_a,
    input  logic                       pwr_ack_b,
    input  logic [SRAM_ACK_W-1:0]      sram_ack,
    input  logic [PROT_W-1:0]          prot_ack,
    output logic [SRAM_LSB+SRAM_REQ_W-1:0] ctl_word,
    output logic [PROT_W-1:0]          prot_req,
    output logic                       island_on,
    output logic                       island_off,
    output logic                       busy,
    output logic                       seq_err,
    output logic                       done
);
    localparam int CTL_W = SRAM_LSB + SRAM_REQ_W;
    localparam bit HAS_SACK = (SRAM_ACK_MASK != '0);
    localparam bit HAS_PROT = (PROT_MASK != '0);
    localparam logic [CTL_W-1:0] OFF_WORD = {{SRAM_REQ_W{1'b1}}, 3'b000, 5'b10010};
    localparam logic [CTL_W-1:0] ON_WORD  = {{SRAM_REQ_W{1'b0}}, 3'b000, 5'b01101};

    seq_state_e        state, state_d;
    logic [CTL_W-1:0]  ctl_q;
    logic [PROT_W-1:0] prot_q;
    logic              done_q;
    logic              waiting, expired, noop;
    logic              pwr_all_on, pwr_all_off, sram_clear, sram_full, prot_clear, prot_full;

    pis_ack_decode #(
        .SRAM_ACK_W(SRAM_ACK_W), .SRAM_ACK_MASK(SRAM_ACK_MASK),
        .PROT_W(PROT_W), .PROT_MASK(PROT_MASK)
    ) u_dec (
        .pwr_ack_a(pwr_ack_a), .pwr_ack_b(pwr_ack_b), .sram_ack(sram_ack), .prot_ack(prot_ack),
        .pwr_all_on(pwr_all_on), .pwr_all_off(pwr_all_off),
        .sram_clear(sram_clear), .sram_full(sram_full),
        .prot_clear(prot_clear), .prot_full(prot_full)
    );

    pis_wait_timer #(.LIMIT(WAIT_LIMIT)) u_tmr (
        .clk(clk), .rst_n(rst_n), .waiting(waiting), .expired(expired)
    );

    // Classify the current state.
    always_comb begin
        waiting = (state inside {U_WPWR, U_WSRAM, U_WPROT, D_WPROT, D_WSRAM, D_WPWR});
        busy    = !(state inside {S_OFF, S_ON, S_PART, S_ERR});
        noop    = (state == S_OFF && !req_on && req_off) || (state == S_ON && !req_off && req_on);
    end

    // Next-state selection, including skipped handshakes.
    always_comb begin
        state_d = state;
        unique case (state)
            S_OFF:   if (req_on) state_d = U_PON1;
            S_ON:    if (req_off) state_d = HAS_PROT ? D_PROT : D_SRAM;
            S_PART:  if (req_on) state_d = U_PON1;
                     else if (req_off) state_d = HAS_PROT ? D_PROT : D_SRAM;
            S_ERR:   if (err_clr) state_d = S_PART;
            U_PON1:  state_d = U_PON2;
            U_PON2:  state_d = U_WPWR;
            U_WPWR:  if (pwr_all_on) state_d = U_CLK; else if (expired) state_d = S_ERR;
            U_CLK:   state_d = U_ISO;
            U_ISO:   state_d = U_RST;
            U_RST:   state_d = U_SRAM;
            U_SRAM:  state_d = HAS_SACK ? U_WSRAM : (HAS_PROT ? U_PROT : S_ON);
            U_WSRAM: if (sram_clear) state_d = HAS_PROT ? U_PROT : S_ON;
                     else if (expired) state_d = S_ERR;
            U_PROT:  state_d = U_WPROT;
            U_WPROT: if (prot_clear) state_d = S_ON; else if (expired) state_d = S_ERR;
            D_PROT:  state_d = D_WPROT;
            D_WPROT: if (prot_full) state_d = D_SRAM; else if (expired) state_d = S_ERR;
            D_SRAM:  state_d = HAS_SACK ? D_WSRAM : D_ISO;
            D_WSRAM: if (sram_full) state_d = D_ISO; else if (expired) state_d = S_ERR;
            D_ISO:   state_d = D_RST;
            D_RST:   state_d = D_CLK;
            D_CLK:   state_d = D_PON1;
            D_PON1:  state_d = D_PON2;
            D_PON2:  state_d = D_WPWR;
            D_WPWR:  if (pwr_all_off) state_d = S_OFF; else if (expired) state_d = S_ERR;
            default: state_d = S_ERR;
        endcase
    end

    // State, control lines and completion pulse; each step state owns one change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_OFF;
            ctl_q  <= OFF_WORD;
            prot_q <= PROT_MASK;
            done_q <= 1'b0;
        end else begin
            state  <= state_d;
            done_q <= noop || (busy && (state_d == S_ON || state_d == S_OFF));
            case (state)
                U_PON1:  ctl_q[BIT_PON1]   <= 1'b1;
                U_PON2:  ctl_q[BIT_PON2]   <= 1'b1;
                U_CLK:   ctl_q[BIT_CLKDIS] <= 1'b0;
                U_ISO:   ctl_q[BIT_ISO]    <= 1'b0;
                U_RST:   ctl_q[BIT_RSTN]   <= 1'b1;
                U_SRAM:  ctl_q[SRAM_LSB +: SRAM_REQ_W] <= '0;
                U_PROT:  prot_q <= '0;
                D_PROT:  prot_q <= PROT_MASK;
                D_SRAM:  ctl_q[SRAM_LSB +: SRAM_REQ_W] <= '1;
                D_ISO:   ctl_q[BIT_ISO]    <= 1'b1;
                D_RST:   ctl_q[BIT_RSTN]   <= 1'b0;
                D_CLK:   ctl_q[BIT_CLKDIS] <= 1'b1;
                D_PON1:  ctl_q[BIT_PON1]   <= 1'b0;
                D_PON2:  ctl_q[BIT_PON2]   <= 1'b0;
                default: ;
            endcase
        end
    end

    assign ctl_word   = ctl_q;
    assign prot_req   = prot_q;
    assign island_on  = (state == S_ON);
    assign island_off = (state == S_OFF);
    assign seq_err    = (state == S_ERR);
    assign done       = done_q;

    assert_off_pattern_R1: assert property (@(posedge clk) disable iff (!rst_n)
        island_off |-> (ctl_word == OFF_WORD && prot_req == PROT_MASK));

    assert_on_pattern_R2: assert property (@(posedge clk) disable iff (!rst_n)
        island_on |-> (ctl_word == ON_WORD && prot_req == '0));

    assert_split_status_waits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == U_WPWR || state == D_WPWR) && (pwr_ack_a != pwr_ack_b))
            |=> (state == $past(state) || state == S_ERR));

    assert_err_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_err && $past(seq_err)) |-> ($stable(ctl_word) && $stable(prot_req)));

    assert_err_after_expiry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_err) |-> $past(expired));

    assert_one_step_per_edge_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ctl_q[SRAM_LSB +: SRAM_REQ_W] != $past(ctl_q[SRAM_LSB +: SRAM_REQ_W]),
                    ctl_q[4:0] ^ $past(ctl_q[4:0]),
                    prot_q != $past(prot_q)}) <= 1);

    assert_live_needs_power_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_word[BIT_RSTN] || !ctl_word[BIT_CLKDIS] || !ctl_word[BIT_ISO])
            |-> (ctl_word[BIT_PON1] && ctl_word[BIT_PON2]));

endmodule

// File: tb/pwr_island_seq_bench.sv
`timescale 1ns/1ps
// Bench: full-mask instance with delayed acknowledge models, swept over delay
// combinations, plus a zero-mask instance for the skipped handshakes.
module pwr_island_seq_bench;
    localparam int TLIM = 16;
    localparam logic [3:0] PMA = 4'b1010;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;

    // Instance A signals
    logic        a_on_req = 0, a_off_req = 0, a_clr = 0;
    logic        a_ack1, a_ack2;
    logic [3:0]  a_sack, a_pack;
    logic [11:0] a_ctl;
    logic [3:0]  a_prot;
    logic        a_ison, a_isoff, a_busy, a_err, a_done;
    // Instance B signals
    logic        b_on_req = 0, b_off_req = 0, b_clr = 0;
    logic [11:0] b_ctl;
    logic [3:0]  b_prot;
    logic        b_ison, b_isoff, b_busy, b_err, b_done;

    // Acknowledge model controls
    int d1 = 0, d2 = 0, ds = 0, dp = 0;
    bit stuck2 = 0;
    logic [3:0] sram_or = 4'b0000;
    logic [7:0] h1 = '0, h2 = '0;
    logic [7:0][3:0] hs = '0, hp = '0;

    pwr_island_seq #(.SRAM_REQ_W(4), .SRAM_ACK_W(4), .SRAM_ACK_MASK(4'b0011),
                     .PROT_W(4), .PROT_MASK(PMA), .WAIT_LIMIT(TLIM)) u_pwr_island_seq (
        .clk(clk), .rst_n(rst_n), .req_on(a_on_req), .req_off(a_off_req), .err_clr(a_clr),
        .pwr_ack_a(a_ack1), .pwr_ack_b(a_ack2), .sram_ack(a_sack), .prot_ack(a_pack),
        .ctl_word(a_ctl), .prot_req(a_prot), .island_on(a_ison), .island_off(a_isoff),
        .busy(a_busy), .seq_err(a_err), .done(a_done));

    pwr_island_seq #(.SRAM_REQ_W(4), .SRAM_ACK_W(4), .SRAM_ACK_MASK(4'b0000),
                     .PROT_W(4), .PROT_MASK(4'b0000), .WAIT_LIMIT(TLIM)) u_pwr_island_seq_skip (
        .clk(clk), .rst_n(rst_n), .req_on(b_on_req), .req_off(b_off_req), .err_clr(b_clr),
        .pwr_ack_a(b_ctl[2]), .pwr_ack_b(b_ctl[3]), .sram_ack(4'b1111), .prot_ack(4'b1111),
        .ctl_word(b_ctl), .prot_req(b_prot), .island_on(b_ison), .island_off(b_isoff),
        .busy(b_busy), .seq_err(b_err), .done(b_done));

    // Delay lines for the acknowledge model of instance A.
    always @(posedge clk) begin
        h1 <= {h1[6:0], a_ctl[2]};
        h2 <= {h2[6:0], a_ctl[3]};
        hs <= {hs[6:0], a_ctl[11:8]};
        hp <= {hp[6:0], a_prot};
    end

    always_comb begin
        a_ack1 = (d1 == 0) ? a_ctl[2] : h1[d1-1];
        a_ack2 = stuck2 ? 1'b0 : ((d2 == 0) ? a_ctl[3] : h2[d2-1]);
        a_sack = ((ds == 0) ? a_ctl[11:8] : hs[ds-1]) | sram_or;
        a_pack = (dp == 0) ? a_prot : hp[dp-1];
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [15:0] snap_of(input bit b);
        return b ? {b_prot, b_ctl} : {a_prot, a_ctl};
    endfunction

    // One sequence step applied to {prot, ctl}; 0..6 power-up, 10..16 power-down.
    function automatic logic [15:0] step_fn(input logic [15:0] w, input int s, input logic [3:0] pm);
        logic [15:0] r = w;
        case (s)
            0:  r[2] = 1'b1;
            1:  r[3] = 1'b1;
            2:  r[4] = 1'b0;
            3:  r[1] = 1'b0;
            4:  r[0] = 1'b1;
            5:  r[11:8] = 4'h0;
            6:  r[15:12] = r[15:12] & ~pm;
            10: r[15:12] = r[15:12] | pm;
            11: r[11:8] = 4'hF;
            12: r[1] = 1'b1;
            13: r[0] = 1'b0;
            14: r[4] = 1'b1;
            15: r[2] = 1'b0;
            16: r[3] = 1'b0;
            default: ;
        endcase
        return r;
    endfunction

    logic [15:0] lg [0:31];
    logic [15:0] lg_start;
    int          lg_n;

    // Issue one request and log every output change until done or error.
    task automatic run_seq(input bit b, input bit up, output int edges, output bit got_err);
        logic [15:0] prev, cur;
        @(negedge clk);
        lg_start = snap_of(b);
        prev = lg_start;
        lg_n = 0;
        edges = 0;
        got_err = 0;
        if (b) begin b_on_req = up; b_off_req = !up; end
        else   begin a_on_req = up; a_off_req = !up; end
        forever begin
            @(negedge clk);
            a_on_req = 0; a_off_req = 0; b_on_req = 0; b_off_req = 0;
            edges++;
            cur = snap_of(b);
            if (cur != prev) begin
                if (lg_n < 32) lg[lg_n] = cur;
                lg_n++;
                prev = cur;
            end
            if (b ? b_done : a_done) break;
            if (b ? b_err : a_err) begin got_err = 1; break; end
            if (edges >= 200) break;
        end
    endtask

    // Compare the logged changes with the ordering computed from the steps.
    task automatic check_log(input bit up, input logic [3:0] pm, input string rq, input string what);
        logic [15:0] w, nw;
        int k = 0;
        bit ok = 1;
        w = lg_start;
        for (int i = 0; i < 7; i++) begin
            nw = step_fn(w, up ? i : i + 10, pm);
            if (nw != w) begin
                if (k >= lg_n || k >= 32 || lg[k] != nw) ok = 0;
                k++;
            end
            w = nw;
        end
        chk(ok && (k == lg_n), rq, what, lg_n, k);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int e;
        bit er;
        logic [15:0] hold;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset pattern on both instances
        chk(a_ctl == 12'hF12, "R1", "A ctl after reset", a_ctl, 12'hF12);
        chk(a_prot == PMA, "R1", "A prot after reset", a_prot, PMA);
        chk(a_isoff && !a_ison && !a_busy && !a_err && !a_done, "R1", "A status after reset",
            {a_isoff, a_ison, a_busy, a_err, a_done}, 5'b10000);
        chk(b_ctl == 12'hF12 && b_prot == 4'h0, "R1", "B outputs after reset", {b_prot, b_ctl}, 16'h0F12);

        // R11: off request while off is a no-op
        idle(8);
        run_seq(0, 0, e, er);
        chk(e == 1 && lg_n == 0 && a_isoff, "R11", "off while off", {e, lg_n}, {32'd1, 32'd0});

        // R2..R7: sweep of acknowledge delays, up then down
        for (int i1 = 0; i1 < 4; i1++)
        for (int i2 = 0; i2 < 4; i2++)
        for (int is = 0; is < 3; is++)
        for (int ip = 0; ip < 3; ip++) begin
            int mx;
            d1 = i1; d2 = i2; ds = is; dp = ip;
            idle(8);
            run_seq(0, 1, e, er);
            mx = (2 + i1 > 3 + i2) ? 2 + i1 : 3 + i2;
            chk(!er && e == mx + 8 + is + ip, "R3", "up latency", e, mx + 8 + is + ip);
            check_log(1, PMA, "R2", "up ordering");
            chk(a_ison && a_ctl == 12'h00D && a_prot == 4'h0, "R5", "on after up",
                {a_ison, a_prot, a_ctl}, {1'b1, 16'h000D});
            idle(8);
            run_seq(0, 0, e, er);
            mx = (9 + i1 > 10 + i2) ? 9 + i1 : 10 + i2;
            chk(!er && e == mx + 1 + is + ip, "R7", "down latency", e, mx + 1 + is + ip);
            check_log(0, PMA, "R6", "down ordering");
            chk(a_isoff && a_ctl == 12'hF12, "R7", "off after down", a_ctl, 12'hF12);
        end
        d1 = 0; d2 = 0; ds = 0; dp = 0;

        // R4: unmasked SRAM ack bit set does not block power-up
        idle(8);
        sram_or = 4'b1000;
        run_seq(0, 1, e, er);
        chk(!er && e == 11 && a_ison, "R4", "unmasked sram ack ignored", e, 11);
        // R11: on request while on is a no-op
        run_seq(0, 1, e, er);
        chk(e == 1 && lg_n == 0 && a_ison, "R11", "on while on", {e, lg_n}, {32'd1, 32'd0});
        idle(4);
        run_seq(0, 0, e, er);
        chk(!er && a_isoff, "R6", "down with unmasked sram ack", a_isoff, 1);

        // R3/R9: only one status input rises -> timeout
        idle(8);
        sram_or = 4'b0000;
        stuck2 = 1;
        run_seq(0, 1, e, er);
        chk(er && e == TLIM + 3, "R9", "split status timeout edge", e, TLIM + 3);
        chk(!a_ison && a_ack1 && !a_ack2, "R3", "one status on is not on", {a_ison, a_ack1, a_ack2}, 3'b010);
        hold = snap_of(0);
        // R10: requests ignored while in error
        a_off_req = 1; idle(1); a_off_req = 0; a_on_req = 1; idle(1); a_on_req = 0;
        idle(4);
        chk(snap_of(0) == hold && a_err, "R10", "frozen under requests", snap_of(0), hold);
        a_clr = 1; idle(1); a_clr = 0;
        chk(!a_err && !a_ison && !a_isoff && !a_busy, "R10", "status after clear",
            {a_err, a_ison, a_isoff, a_busy}, 4'b0000);
        stuck2 = 0;
        idle(4);
        run_seq(0, 0, e, er);
        check_log(0, PMA, "R10", "down ordering from partial");
        chk(!er && a_isoff && a_ctl == 12'hF12, "R10", "off after partial", a_ctl, 12'hF12);

        // R4/R9: masked SRAM ack bit stuck high -> timeout in SRAM wait
        idle(8);
        sram_or = 4'b0001;
        run_seq(0, 1, e, er);
        chk(er && e == TLIM + 8, "R4", "sram wait timeout edge", e, TLIM + 8);
        chk(a_ctl == 12'h00D && a_prot == PMA, "R9", "outputs at sram timeout", {a_prot, a_ctl}, {PMA, 12'h00D});
        a_clr = 1; idle(1); a_clr = 0;
        sram_or = 4'b0000;
        idle(2);
        run_seq(0, 0, e, er);
        check_log(0, PMA, "R10", "down after sram error");
        chk(!er && a_isoff, "R10", "off after sram error", a_isoff, 1);

        // R8: zero masks skip SRAM and protection handshakes
        idle(4);
        run_seq(1, 1, e, er);
        chk(!er && e == 8 && b_ison, "R8", "skip up latency", e, 8);
        check_log(1, 4'h0, "R8", "skip up ordering");
        idle(4);
        run_seq(1, 0, e, er);
        chk(!er && e == 8 && b_isoff, "R8", "skip down latency", e, 8);
        check_log(0, 4'h0, "R8", "skip down ordering");
        chk(b_prot == 4'h0 && !b_err, "R12", "skip instance clean", {b_err, b_prot}, 5'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R12: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule